// File: doc/BRIEF.md
# Configurable I/O Pin Multiplexer

This block shares a set of I/O pads among several peripheral functions. A 2-bit select field per pad chooses what drives that pad. Code 0 is always the plain GPIO path, driven by the GPIO value and direction registers. Codes 1 to 3 hand the pad's output value to one of three peripheral functions. A function that raises its control flag also takes over the pad's output enable and pull controls from the registers. The path from the output registers and function outputs to the pad is purely combinational, so it adds a single mux level and no registers. Per-pad registers set open-drain mode, pull-up and pull-down, and a 2-bit drive strength.

The input side is turned round. Each peripheral input owns a selector register that names at most one pad, so two pads can never contend for one function input. Selector code 0, or any code above the pad count, yields the idle level 0. Each pad's input can optionally pass through a debounce filter. A shared tick divider sets the filter's sample rate, and a programmable count sets how many consecutive differing samples are needed before a new level is accepted. Debounce is enabled per pad, so it can be limited to pads that carry external interrupts.

Software programs the block through a simple write/read bus. Writes take effect on the next clock edge. Read data is registered and appears one cycle after the address is presented.

Top module: `pinmux_top`

## Requirements
- R1: After reset, every pad select is 0 (GPIO), every output enable, pull-up, pull-down, open-drain, drive strength and debounce enable register is 0, every input selector is 0 and every function input reads 0. The tick divider resets to 0 and the stable count resets to 1.
- R2: Register map (word addresses): 0 = pad selects (2 bits per pad, pad p at bits 2p+1:2p); 1 = GPIO value; 2 = GPIO output enable; 3 = pull-up; 4 = pull-down; 5 = open-drain; 6 = drive strength (2 bits per pad, same layout as address 0); 7 = debounce enable; 8 = tick divider; 9 = stable count; 16+j = input selector for function input j. A write is visible from the next cycle. `rdata` shows the register at `addr` one cycle after `addr` is presented, and unmapped addresses read 0.
- R3: With select 0, pad p drives the GPIO value bit p. With select k (1 to 3), pad p drives `fn_o[(k-1)*NUM_PADS+p]` in the same cycle.
- R4: With select k not 0 and `fn_ctl[k-1]` high, the pad's output enable, pull-up and pull-down come from the function's `fn_oe`, `fn_pu` and `fn_pd` bits. Otherwise they come from the registers.
- R5: In open-drain mode, `pad_o` is 0 and `pad_oe` is high only when the selected output value is 0 and its output enable is high.
- R6: If pull-up and pull-down are both requested for a pad, `pad_pu` is 1 and `pad_pd` is 0.
- R7: `pad_ds` always equals the drive-strength register, whatever the select.
- R8: Function input j reads pad s-1 when its selector s is in 1..NUM_PADS. Otherwise it reads 0.
- R9: With debounce disabled on a pad, a function input routed to that pad follows `pad_in` in the same cycle.
- R10: With debounce enabled, a tick occurs once every divider+1 cycles. A pad's filtered level changes only on a tick edge, after the raw level has differed from it on N consecutive ticks (N = stable count, with 0 treated as 1). A tick on which the raw level agrees restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| fn_o | input | 3*NUM_PADS | Function output values, function k-1 at bits (k-1)*NUM_PADS+p |
| fn_oe | input | 3*NUM_PADS | Function output enables, same layout |
| fn_pu | input | 3*NUM_PADS | Function pull-up requests, same layout |
| fn_pd | input | 3*NUM_PADS | Function pull-down requests, same layout |
| fn_ctl | input | 3 | Per function: function owns direction and pulls |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_o | output | NUM_PADS | Pad output value |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_pu | output | NUM_PADS | Pad pull-up enable |
| pad_pd | output | NUM_PADS | Pad pull-down enable |
| pad_ds | output | 2*NUM_PADS | Pad drive strength, 2 bits per pad |
| fn_in | output | NUM_IN | Peripheral function inputs |

## Verification
The pad outputs and undebounced function inputs are due in the same cycle as the input that causes them. A register write shows on them from the cycle after its edge. Read data is due one cycle after the address, and a debounced level is due on the tick edge that completes the Nth differing sample. The bench's model advances its state on each rising edge from the inputs that edge samples. It compares every output on the falling edge, with inputs driven just after the rising edge. Each result is therefore checked in exactly the cycle it is due, neither earlier nor later.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int ADDR_W = 5;
  localparam int NFN    = 3;     // peripheral functions besides GPIO
  localparam logic IDLE_LVL = 1'b0;

  localparam logic [ADDR_W-1:0] A_FSEL = 5'd0;
  localparam logic [ADDR_W-1:0] A_GOUT = 5'd1;
  localparam logic [ADDR_W-1:0] A_GOE  = 5'd2;
  localparam logic [ADDR_W-1:0] A_PU   = 5'd3;
  localparam logic [ADDR_W-1:0] A_PD   = 5'd4;
  localparam logic [ADDR_W-1:0] A_OD   = 5'd5;
  localparam logic [ADDR_W-1:0] A_DS   = 5'd6;
  localparam logic [ADDR_W-1:0] A_DBEN = 5'd7;
  localparam logic [ADDR_W-1:0] A_DIV  = 5'd8;
  localparam logic [ADDR_W-1:0] A_NSTB = 5'd9;
  localparam int                A_ISEL = 16;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int P      = 8,
  parameter int NUM_IN = 4,
  parameter int SEL_W  = 4,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic [2*P-1:0]          fsel_q,
  output logic [P-1:0]            gout_q,
  output logic [P-1:0]            goe_q,
  output logic [P-1:0]            pu_q,
  output logic [P-1:0]            pd_q,
  output logic [P-1:0]            od_q,
  output logic [2*P-1:0]          ds_q,
  output logic [P-1:0]            dben_q,
  output logic [DIV_W-1:0]        div_q,
  output logic [CNT_W-1:0]        nstb_q,
  output logic [NUM_IN*SEL_W-1:0] isel_q
);
  logic [DATA_W-1:0] rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q <= '0; gout_q <= '0; goe_q <= '0; pu_q <= '0; pd_q <= '0;
      od_q <= '0; ds_q <= '0; dben_q <= '0; div_q <= '0;
      nstb_q <= CNT_W'(1); isel_q <= '0; rdata <= '0;
    end else begin
      rdata <= rd;
      if (wr_en) begin
        case (addr)
          A_FSEL: fsel_q <= wdata[2*P-1:0];
          A_GOUT: gout_q <= wdata[P-1:0];
          A_GOE:  goe_q  <= wdata[P-1:0];
          A_PU:   pu_q   <= wdata[P-1:0];
          A_PD:   pd_q   <= wdata[P-1:0];
          A_OD:   od_q   <= wdata[P-1:0];
          A_DS:   ds_q   <= wdata[2*P-1:0];
          A_DBEN: dben_q <= wdata[P-1:0];
          A_DIV:  div_q  <= wdata[DIV_W-1:0];
          A_NSTB: nstb_q <= wdata[CNT_W-1:0];
          default: begin
            for (int j = 0; j < NUM_IN; j++)
              if (addr == ADDR_W'(A_ISEL + j)) isel_q[j*SEL_W +: SEL_W] <= wdata[SEL_W-1:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    rd = '0;
    case (addr)
      A_FSEL: rd = DATA_W'(fsel_q);
      A_GOUT: rd = DATA_W'(gout_q);
      A_GOE:  rd = DATA_W'(goe_q);
      A_PU:   rd = DATA_W'(pu_q);
      A_PD:   rd = DATA_W'(pd_q);
      A_OD:   rd = DATA_W'(od_q);
      A_DS:   rd = DATA_W'(ds_q);
      A_DBEN: rd = DATA_W'(dben_q);
      A_DIV:  rd = DATA_W'(div_q);
      A_NSTB: rd = DATA_W'(nstb_q);
      default: begin
        for (int j = 0; j < NUM_IN; j++)
          if (addr == ADDR_W'(A_ISEL + j)) rd = DATA_W'(isel_q[j*SEL_W +: SEL_W]);
      end
    endcase
  end

  assert_fsel_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == A_FSEL) |-> fsel_q == $past(wdata[2*P-1:0]));

  assert_ds_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == A_DS) |-> ds_q == $past(wdata[2*P-1:0]));
endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
  import pinmux_pkg::*;
(
  input  logic [1:0]     sel,
  input  logic           g_o,
  input  logic           g_oe,
  input  logic           r_pu,
  input  logic           r_pd,
  input  logic           od,
  input  logic [NFN-1:0] f_o,
  input  logic [NFN-1:0] f_oe,
  input  logic [NFN-1:0] f_pu,
  input  logic [NFN-1:0] f_pd,
  input  logic [NFN-1:0] f_ctl,
  output logic           o,
  output logic           oe,
  output logic           pu,
  output logic           pd
);
  logic o_raw, oe_raw, pu_raw, pd_raw;

  always_comb begin
    o_raw = g_o; oe_raw = g_oe; pu_raw = r_pu; pd_raw = r_pd;
    for (int k = 0; k < NFN; k++) begin
      if (int'(sel) == k + 1) begin
        o_raw = f_o[k];
        if (f_ctl[k]) begin
          oe_raw = f_oe[k]; pu_raw = f_pu[k]; pd_raw = f_pd[k];
        end
      end
    end
    if (od) begin
      o  = 1'b0;
      oe = oe_raw & ~o_raw;
    end else begin
      o  = o_raw;
      oe = oe_raw;
    end
    pu = pu_raw;
    pd = pd_raw & ~pu_raw;
  end
endmodule

// File: rtl/pinmux_debounce.sv
module pinmux_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] nstb,
  input  logic             raw,
  output logic             filt
);
  logic             stb_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_nxt;

  assign run_nxt = {1'b0, run_q} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      run_q <= '0;
    end else if (!en) begin
      stb_q <= raw;
      run_q <= '0;
    end else if (tick) begin
      if (raw != stb_q) begin
        if (run_nxt >= {1'b0, nstb}) begin
          stb_q <= raw;
          run_q <= '0;
        end else begin
          run_q <= run_nxt[CNT_W-1:0];
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign filt = en ? stb_q : raw;

  assert_change_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && stb_q != $past(stb_q)) |-> $past(tick));

  assert_change_follows_raw_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && stb_q != $past(stb_q)) |-> stb_q == $past(raw));
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int NUM_IN   = 4,
  parameter int DIV_W    = 16,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [NFN*NUM_PADS-1:0] fn_o,
  input  logic [NFN*NUM_PADS-1:0] fn_oe,
  input  logic [NFN*NUM_PADS-1:0] fn_pu,
  input  logic [NFN*NUM_PADS-1:0] fn_pd,
  input  logic [NFN-1:0]        fn_ctl,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_o,
  output logic [NUM_PADS-1:0]   pad_oe,
  output logic [NUM_PADS-1:0]   pad_pu,
  output logic [NUM_PADS-1:0]   pad_pd,
  output logic [2*NUM_PADS-1:0] pad_ds,
  output logic [NUM_IN-1:0]     fn_in
);
  localparam int P     = NUM_PADS;
  localparam int SEL_W = $clog2(NUM_PADS + 1);

  logic [2*P-1:0]          fsel_q, ds_q;
  logic [P-1:0]            gout_q, goe_q, pu_q, pd_q, od_q, dben_q, filt;
  logic [DIV_W-1:0]        div_q, tcnt_q;
  logic [CNT_W-1:0]        nstb_q;
  logic [NUM_IN*SEL_W-1:0] isel_q;
  logic                    tick;

  pinmux_regs #(.P(P), .NUM_IN(NUM_IN), .SEL_W(SEL_W), .DIV_W(DIV_W),
                .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .fsel_q(fsel_q), .gout_q(gout_q), .goe_q(goe_q), .pu_q(pu_q), .pd_q(pd_q),
    .od_q(od_q), .ds_q(ds_q), .dben_q(dben_q), .div_q(div_q), .nstb_q(nstb_q),
    .isel_q(isel_q));

  // shared sample-rate divider for all debounce filters
  assign tick = (tcnt_q == div_q);
  always_ff @(posedge clk) begin
    if (rst)       tcnt_q <= '0;
    else if (tick) tcnt_q <= '0;
    else           tcnt_q <= tcnt_q + DIV_W'(1);
  end

  assign pad_ds = ds_q;

  for (genvar p = 0; p < P; p++) begin : g_pad
    logic [NFN-1:0] lo, loe, lpu, lpd;
    logic           o, oe, pu, pd;
    always_comb begin
      for (int k = 0; k < NFN; k++) begin
        lo[k]  = fn_o[k*P + p];
        loe[k] = fn_oe[k*P + p];
        lpu[k] = fn_pu[k*P + p];
        lpd[k] = fn_pd[k*P + p];
      end
    end

    pinmux_lane u_lane (
      .sel(fsel_q[2*p +: 2]), .g_o(gout_q[p]), .g_oe(goe_q[p]), .r_pu(pu_q[p]),
      .r_pd(pd_q[p]), .od(od_q[p]), .f_o(lo), .f_oe(loe), .f_pu(lpu), .f_pd(lpd),
      .f_ctl(fn_ctl), .o(o), .oe(oe), .pu(pu), .pd(pd));

    assign pad_o[p]  = o;
    assign pad_oe[p] = oe;
    assign pad_pu[p] = pu;
    assign pad_pd[p] = pd;

    pinmux_debounce #(.CNT_W(CNT_W)) u_db (
      .clk(clk), .rst(rst), .en(dben_q[p]), .tick(tick), .nstb(nstb_q),
      .raw(pad_in[p]), .filt(filt[p]));

    assert_od_release_R5: assert property (@(posedge clk) disable iff (rst)
      (od_q[p] && fsel_q[2*p +: 2] == 2'd0 && pad_oe[p]) |-> !gout_q[p]);

    assert_pullup_wins_R6: assert property (@(posedge clk) disable iff (rst)
      (fsel_q[2*p +: 2] == 2'd0 && pu_q[p]) |-> (pad_pu[p] && !pad_pd[p]));
  end

  for (genvar j = 0; j < NUM_IN; j++) begin : g_in
    logic [SEL_W-1:0] s;
    logic             v;
    assign s = isel_q[j*SEL_W +: SEL_W];
    always_comb begin
      v = IDLE_LVL;
      for (int p = 0; p < P; p++)
        if (int'(s) == p + 1) v = filt[p];
    end
    assign fn_in[j] = v;

    assert_idle_input_R8: assert property (@(posedge clk) disable iff (rst)
      (s == '0) |-> (fn_in[j] == IDLE_LVL));
  end
endmodule

// File: tb/tb_pinmux_top.sv
module tb_pinmux_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8, NI = 4, SW = 4, DIVW = 16, CW = 8, DW = 16, NF = 3;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [4:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NF*P-1:0] fn_o = '0, fn_oe = '0, fn_pu = '0, fn_pd = '0;
  logic [NF-1:0] fn_ctl = '0;
  logic [P-1:0] pad_in = '0, pad_o, pad_oe, pad_pu, pad_pd;
  logic [2*P-1:0] pad_ds;
  logic [NI-1:0] fn_in;

  pinmux_top #(.NUM_PADS(P), .NUM_IN(NI), .DIV_W(DIVW), .CNT_W(CW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .fn_o(fn_o), .fn_oe(fn_oe), .fn_pu(fn_pu), .fn_pd(fn_pd), .fn_ctl(fn_ctl),
    .pad_in(pad_in), .pad_o(pad_o), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_ds(pad_ds), .fn_in(fn_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  string tag = "R1";
  bit started = 0, done = 0;

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference state
  logic [2*P-1:0] m_fsel, m_ds;
  logic [P-1:0] m_gout, m_goe, m_pu, m_pd, m_od, m_dben, m_stb;
  logic [DIVW-1:0] m_div, m_tcnt;
  logic [CW-1:0] m_n;
  logic [SW-1:0] m_isel [NI];
  int m_run [P];
  logic [DW-1:0] m_rd;

  function automatic logic [DW-1:0] mread(logic [4:0] a);
    case (a)
      0: return m_fsel;   1: return DW'(m_gout); 2: return DW'(m_goe);
      3: return DW'(m_pu); 4: return DW'(m_pd);  5: return DW'(m_od);
      6: return m_ds;     7: return DW'(m_dben); 8: return m_div;
      9: return DW'(m_n);
      16, 17, 18, 19: return DW'(m_isel[a - 16]);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_fsel = '0; m_ds = '0; m_gout = '0; m_goe = '0; m_pu = '0; m_pd = '0;
      m_od = '0; m_dben = '0; m_stb = '0; m_div = '0; m_tcnt = '0; m_n = 1;
      m_rd = '0;
      for (int j = 0; j < NI; j++) m_isel[j] = '0;
      for (int p = 0; p < P; p++) m_run[p] = 0;
    end else begin
      bit tk;
      m_rd = mread(addr);
      tk = (m_tcnt == m_div);
      m_tcnt = tk ? '0 : m_tcnt + 1'b1;
      for (int p = 0; p < P; p++) begin
        if (!m_dben[p]) begin m_stb[p] = pad_in[p]; m_run[p] = 0; end
        else if (tk) begin
          if (pad_in[p] != m_stb[p]) begin
            if (m_run[p] + 1 >= int'(m_n)) begin m_stb[p] = pad_in[p]; m_run[p] = 0; end
            else m_run[p]++;
          end else m_run[p] = 0;
        end
      end
      if (wr_en) begin
        case (addr)
          0: m_fsel = wdata; 1: m_gout = wdata[P-1:0]; 2: m_goe = wdata[P-1:0];
          3: m_pu = wdata[P-1:0]; 4: m_pd = wdata[P-1:0]; 5: m_od = wdata[P-1:0];
          6: m_ds = wdata; 7: m_dben = wdata[P-1:0]; 8: m_div = wdata;
          9: m_n = wdata[CW-1:0];
          16, 17, 18, 19: m_isel[addr - 16] = wdata[SW-1:0];
          default: ;
        endcase
      end
    end
  end

  // compare every output on each falling edge
  always @(negedge clk) begin
    if (started && !done) begin
      logic [P-1:0] eo, eoe, epu, epd;
      logic [NI-1:0] ein;
      for (int p = 0; p < P; p++) begin
        int sel;
        logic o, oe, pu, pd;
        sel = int'(m_fsel[2*p +: 2]);
        o = m_gout[p]; oe = m_goe[p]; pu = m_pu[p]; pd = m_pd[p];
        if (sel != 0) begin
          o = fn_o[(sel-1)*P + p];
          if (fn_ctl[sel-1]) begin
            oe = fn_oe[(sel-1)*P + p]; pu = fn_pu[(sel-1)*P + p]; pd = fn_pd[(sel-1)*P + p];
          end
        end
        if (m_od[p]) begin oe = oe & !o; o = 0; end
        if (pu) pd = 0;
        eo[p] = o; eoe[p] = oe; epu[p] = pu; epd[p] = pd;
      end
      for (int j = 0; j < NI; j++) begin
        int s;
        s = int'(m_isel[j]);
        if (s == 0 || s > P) ein[j] = 0;
        else ein[j] = m_dben[s-1] ? m_stb[s-1] : pad_in[s-1];
      end
      check("pad_o", 32'(pad_o), 32'(eo));
      check("pad_oe", 32'(pad_oe), 32'(eoe));
      check("pad_pu", 32'(pad_pu), 32'(epu));
      check("pad_pd", 32'(pad_pd), 32'(epd));
      check("pad_ds", 32'(pad_ds), 32'(m_ds));
      check("fn_in", 32'(fn_in), 32'(ein));
      check("rdata", 32'(rdata), 32'(m_rd));
    end
  end

  task automatic step(int n, bit rnd_fn, bit rnd_pad);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (rnd_fn) begin
        fn_o = NF*P'($urandom); fn_oe = NF*P'($urandom);
        fn_pu = NF*P'($urandom); fn_pd = NF*P'($urandom); fn_ctl = NF'($urandom);
      end
      if (rnd_pad) pad_in = P'($urandom);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = 5'(a); wdata = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(posedge clk);
    #2 rst = 0;
    step(3, 0, 0);
    check("fn_in idle", 32'(fn_in), 0);

    // R2: write then read back every register
    tag = "R2";
    wr(0, 16'h1B6C); wr(1, 16'h00A5); wr(2, 16'h00F0); wr(6, 16'h9C3A);
    wr(8, 16'h0002); wr(9, 16'h0004); wr(16, 16'h0003); wr(19, 16'h000F);
    for (int a = 0; a < 22; a++) begin
      @(posedge clk); #2; addr = 5'(a);
    end
    step(2, 0, 0);
    wr(8, 0); wr(9, 1);

    // R3: GPIO and function output routing
    tag = "R3";
    wr(5, 0); wr(0, 16'hE4E4); wr(2, 16'h00FF); wr(1, 16'h0033);
    fn_ctl = 0;
    step(30, 1, 0);
    fn_ctl = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #2;
      fn_o = NF*P'($urandom); fn_ctl = 0;
    end

    // R4: function-owned direction and pulls
    tag = "R4";
    wr(0, 16'hFFFF); step(20, 1, 0);
    wr(0, 16'h5555); step(20, 1, 0);
    wr(0, 16'hAAAA); step(20, 1, 0);

    // R5: open-drain
    tag = "R5";
    wr(5, 16'h00FF); wr(0, 16'h0000); wr(1, 16'h0F0F); wr(2, 16'h00FF);
    step(3, 0, 0);
    wr(0, 16'hE4E4); step(20, 1, 0);
    wr(5, 0);

    // R6: pull-up priority
    tag = "R6";
    wr(0, 0); wr(3, 16'h00FF); wr(4, 16'h00FF); step(3, 0, 0);
    wr(3, 16'h000F); step(3, 0, 0);
    wr(0, 16'hFFFF); step(20, 1, 0);

    // R7: drive strength independent of select
    tag = "R7";
    wr(6, 16'h1234); step(2, 0, 0); wr(0, 0); wr(6, 16'hFEDC); step(2, 0, 0);

    // R8 / R9: input selectors without debounce
    tag = "R8";
    wr(7, 0);
    wr(16, 0); wr(17, 1); wr(18, 8); wr(19, 9);
    step(15, 0, 1);
    wr(19, 15); wr(16, 4); step(15, 0, 1);
    tag = "R9";
    wr(17, 3); wr(18, 7); step(20, 0, 1);

    // R10: debounce with divider and stable count
    tag = "R10";
    pad_in = 0;
    wr(16, 1); wr(17, 2); wr(18, 3); wr(19, 8);
    wr(8, 3); wr(9, 3); wr(7, 16'h0003);
    @(posedge clk); #2 pad_in = 8'h03;
    step(25, 0, 0);
    pad_in = 8'h00; step(6, 0, 0);
    pad_in = 8'h03; step(3, 0, 0);
    pad_in = 8'h00; step(20, 0, 0);
    wr(9, 0); wr(8, 0);
    step(20, 0, 1);
    wr(8, 1); wr(9, 2); wr(7, 16'h00FF);
    step(60, 0, 1);
    wr(7, 0); step(5, 0, 1);

    // mixed soak across all controls
    tag = "R3";
    for (int i = 0; i < 40; i++) begin
      wr($urandom_range(0, 9), DW'($urandom));
      step(4, 1, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule